// File: doc/BRIEF.md
# System Time-Base Counter with Compare Interrupt

This block is a free-running time base for a chip. It keeps a 56-bit up-counter that advances on each cycle where a count-tick input is high. It also holds one 64-bit compare value and raises a level interrupt once the counter has reached that value. Software uses a simple 32-bit register bus that has separate read and write strobes. Reads are combinational in the cycle of the strobe, and writes take effect at the clock edge.

Software reads the counter as two 32-bit words. A strobed read of the low word captures the upper counter bits into a shadow register. A later read of the high word returns that shadow, so both halves come from one sample and no retry loop is needed. The match test is greater-or-equal, so a deadline that is already in the past still produces an interrupt. Software acknowledges the interrupt by clearing the enable bit.

Typical use: clear enable, read the counter, write both compare halves, set enable, and clear enable again in the interrupt handler.

Top module: `sysctr_cmp`

## Requirements
- R1: A synchronous reset clears the counter, both compare halves, the control register and the shadow register. The interrupt is low after reset.
- R2: The counter increments by exactly one at each clock edge where `tick` is high. It holds its value otherwise.
- R3: A strobed read at byte offset 0x00 returns counter bits 31:0 and captures counter bits 55:32 into the shadow. A read at offset 0x04 returns the shadow zero-extended, with bits 31:24 reading as zero. The shadow changes only on a strobed read of offset 0x00.
- R4: Offset 0x08 holds compare bits 31:0. Offset 0x0C holds compare bits 55:32 and keeps only write-data bits 23:0. Compare bits 63:56 are always zero, and 0x0C reads back with bits 31:24 zero.
- R5: Offset 0x10 is the control register. Bit 0 is the enable and can be read and written. Bit 2 is the interrupt status and is read-only, so writes to it are ignored. All other bits read as zero.
- R6: The status bit sets at the clock edge that follows a cycle in which enable is 1 and the counter (zero-extended to 64 bits) is greater than or equal to the compare value. Once set, it stays set while enable stays 1, even if the compare value moves into the future.
- R7: A write that clears enable clears the status bit and the interrupt at that same edge. While enable is 0, the status bit and the interrupt stay low whatever the compare value is.
- R8: The `irq` output always equals the status bit.
- R9: Writes to offsets 0x00 and 0x04 have no effect on the counter.
- R10: A read of an unmapped offset returns zero, and `rdata` is zero while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable; the counter advances on edges where it is high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid in the cycle `rd_en` is high |
| irq | output | 1 | Level interrupt, equal to the status bit |

## Verification
The embedded properties check these rules on every cycle:
- the counter steps by one or holds, according to `tick`;
- the shadow changes only on a strobed low read, and then holds the upper counter bits of the cycle before;
- status never appears while enable is clear, sets one edge after a qualified match, stays sticky, and is dropped by clearing enable.

Some behaviour can only be shown by the bench's scenarios:
- tear-free readout across a carry into the upper half, shown on a narrow second instance where that carry happens within a few hundred ticks;
- the exact firing cycle as the counter passes a future compare value;
- read-back masking of the compare high word;
- writes to the counter and status that are ignored;
- zero data for unmapped offsets.

// File: rtl/sysctr_pkg.sv
`timescale 1ns/1ps
package sysctr_pkg;
   // byte offsets of the register map
   localparam int OFS_CNT_LO = 'h00;
   localparam int OFS_CNT_HI = 'h04;
   localparam int OFS_CMP_LO = 'h08;
   localparam int OFS_CMP_HI = 'h0C;
   localparam int OFS_CTRL   = 'h10;
   // control register bit positions
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_STAT_BIT = 2;
   localparam int MIN_ADDR_W    = 5;
endpackage

// File: rtl/sysctr_counter.sv
`timescale 1ns/1ps
module sysctr_counter #(
   parameter int CNT_W = 56
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
      tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt_q));
endmodule

// File: rtl/sysctr_cmp_unit.sv
`timescale 1ns/1ps
module sysctr_cmp_unit #(
   parameter int CNT_W = 56,
   parameter int CMP_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,      // enable as registered now
   input  logic             en_next_i, // enable after this edge
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CMP_W-1:0] cmp_i,
   output logic             status_o
);
   logic [CMP_W-1:0] cnt_ext;
   logic             match;
   logic             status_q;

   generate
      if (CNT_W == CMP_W) begin : g_same
         assign cnt_ext = cnt_i;
      end else begin : g_pad
         assign cnt_ext = {{(CMP_W-CNT_W){1'b0}}, cnt_i};
      end
   endgenerate

   assign match = (cnt_ext >= cmp_i);

   always_ff @(posedge clk) begin
      if (rst) status_q <= 1'b0;
      else     status_q <= en_next_i & (status_q | (en_i & match));
   end

   assign status_o = status_q;

   p_quiet_off_r7: assert property (@(posedge clk) disable iff (rst)
      !en_i |-> !status_q);
   p_clear_r7: assert property (@(posedge clk) disable iff (rst)
      !en_next_i |=> !status_q);
   p_fire_r6: assert property (@(posedge clk) disable iff (rst)
      (en_i && en_next_i && match) |=> status_q);
   p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (status_q && en_next_i) |=> status_q);
endmodule

// File: rtl/sysctr_readout.sv
`timescale 1ns/1ps
module sysctr_readout
   import sysctr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 56,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [DATA_W-1:0] cmp_lo_i,
   input  logic [CNT_W-DATA_W-1:0] cmp_hi_i,
   input  logic              en_i,
   input  logic              status_i,
   output logic [DATA_W-1:0] rdata
);
   localparam int HI_W = CNT_W - DATA_W;

   logic [HI_W-1:0] shadow_q;
   logic            lo_hit;

   assign lo_hit = rd_en && (addr == ADDR_W'(OFS_CNT_LO));

   always_ff @(posedge clk) begin
      if (rst)         shadow_q <= '0;
      else if (lo_hit) shadow_q <= cnt_i[CNT_W-1:DATA_W];
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (addr)
            ADDR_W'(OFS_CNT_LO): rdata = cnt_i[DATA_W-1:0];
            ADDR_W'(OFS_CNT_HI): rdata = DATA_W'(shadow_q);
            ADDR_W'(OFS_CMP_LO): rdata = cmp_lo_i;
            ADDR_W'(OFS_CMP_HI): rdata = DATA_W'(cmp_hi_i);
            ADDR_W'(OFS_CTRL): begin
               rdata[CTRL_EN_BIT]   = en_i;
               rdata[CTRL_STAT_BIT] = status_i;
            end
            default: rdata = '0;
         endcase
      end
   end

   p_shadow_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !lo_hit |=> $stable(shadow_q));
   p_shadow_cap_r3: assert property (@(posedge clk) disable iff (rst)
      lo_hit |=> (shadow_q == $past(cnt_i[CNT_W-1:DATA_W])));
endmodule

// File: rtl/sysctr_cmp.sv
`timescale 1ns/1ps
module sysctr_cmp
   import sysctr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 56,
   parameter int CMP_W  = 64,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   localparam int HI_W = CNT_W - DATA_W;

   generate
      if (CMP_W != 2 * DATA_W) begin : g_bad_cmp
         $error("compare width must be two data words");
      end
      if (CNT_W <= DATA_W || CNT_W > CMP_W) begin : g_bad_cnt
         $error("counter width must lie above one word and within compare width");
      end
      if (DATA_W <= CTRL_STAT_BIT || ADDR_W < MIN_ADDR_W) begin : g_bad_bus
         $error("bus too narrow for register map");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] cmp_lo_q;
   logic [HI_W-1:0]   cmp_hi_q;
   logic              en_q, en_d;
   logic              status;
   logic              wr_ctrl;
   logic [CMP_W-1:0]  cmp_full;
   logic              unused_wdata;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
   assign en_d    = wr_ctrl ? wdata[CTRL_EN_BIT] : en_q;
   assign unused_wdata = ^wdata[DATA_W-1:HI_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         cmp_lo_q <= '0;
         cmp_hi_q <= '0;
         en_q     <= 1'b0;
      end else begin
         en_q <= en_d;
         if (wr_en && addr == ADDR_W'(OFS_CMP_LO)) cmp_lo_q <= wdata;
         if (wr_en && addr == ADDR_W'(OFS_CMP_HI)) cmp_hi_q <= wdata[HI_W-1:0];
      end
   end

   assign cmp_full = CMP_W'({cmp_hi_q, cmp_lo_q});

   sysctr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst(rst), .tick(tick), .cnt_o(cnt)
   );

   sysctr_cmp_unit #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cmp (
      .clk(clk), .rst(rst), .en_i(en_q), .en_next_i(en_d),
      .cnt_i(cnt), .cmp_i(cmp_full), .status_o(status)
   );

   sysctr_readout #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_readout (
      .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .cnt_i(cnt),
      .cmp_lo_i(cmp_lo_q), .cmp_hi_i(cmp_hi_q), .en_i(en_q),
      .status_i(status), .rdata(rdata)
   );

   assign irq = status;

   p_ctrl_follow_r5: assert property (@(posedge clk) disable iff (rst)
      wr_ctrl |=> (en_q == $past(wdata[CTRL_EN_BIT])));
endmodule

// File: tb/sysctr_cmp_bench.sv
`timescale 1ns/1ps
module sysctr_cmp_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0;
   logic rd_en = 1'b0, wr_en = 1'b0;
   logic [4:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic irq;
   logic rd_en_s = 1'b0;
   logic [4:0] addr_s = '0;
   logic [7:0] rdata_s;
   logic irq_s;

   int n_vec = 0;
   int n_bad = 0;
   longint unsigned m_cnt = 0;

   typedef struct { logic [31:0] exp; bit sm; string tag; } item_t;
   item_t sb_q[$];
   event sample_ev;

   always #5 clk = ~clk;

   sysctr_cmp u_sysctr_cmp (
      .clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // narrow instance: carry into the upper half is reachable in 256 ticks
   sysctr_cmp #(.DATA_W(8), .CNT_W(14), .CMP_W(16), .ADDR_W(5)) u_small (
      .clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en_s), .wr_en(1'b0),
      .addr(addr_s), .wdata(8'h00), .rdata(rdata_s), .irq(irq_s)
   );

   // bench's own count of ticks
   always @(posedge clk) begin
      if (rst)       m_cnt <= 0;
      else if (tick) m_cnt <= m_cnt + 1;
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expectations and compares them against the bus
   initial begin
      forever begin
         @(sample_ev);
         #2;
         begin
            item_t it;
            it = sb_q.pop_front();
            check(it.sm ? {24'h0, rdata_s} : rdata, it.exp, it.tag);
         end
      end
   end

   // all tasks start at a negedge and end at a negedge
   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag, input bit sm = 1'b0);
      item_t it;
      if (sm) begin rd_en_s = 1'b1; addr_s = a; end
      else    begin rd_en   = 1'b1; addr   = a; end
      it.exp = exp; it.sm = sm; it.tag = tag;
      sb_q.push_back(it);
      -> sample_ev;
      @(negedge clk);
      rd_en = 1'b0; rd_en_s = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] cmpv;
      logic [5:0]  hi_s;
      bit          prev;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check({31'h0, irq}, 32'h0, "R1 irq after reset");
      rd(5'h00, 32'h0, "R1 cnt lo");
      rd(5'h04, 32'h0, "R1 cnt hi");
      rd(5'h08, 32'h0, "R1 cmp lo");
      rd(5'h0C, 32'h0, "R1 cmp hi");
      rd(5'h10, 32'h0, "R1 ctrl");
      // R2 hold without tick, then count
      repeat (5) @(negedge clk);
      rd(5'h00, 32'h0, "R2 hold without tick");
      tick = 1'b1;
      repeat (37) @(negedge clk);
      rd(5'h00, m_cnt[31:0], "R2 count with tick");
      tick = 1'b0;
      rd(5'h00, m_cnt[31:0], "R2 count after stop");
      rd(5'h04, 32'h0, "R3 high word zero");
      // R3 tear-free split read across a carry (narrow instance)
      tick = 1'b1;
      while (m_cnt[7:0] != 8'hFF) @(negedge clk);
      hi_s = m_cnt[13:8];
      rd(5'h00, 32'hFF, "R3 small low at carry", 1'b1);
      rd(5'h04, {26'h0, hi_s}, "R3 small high latched", 1'b1);
      rd(5'h04, {26'h0, hi_s}, "R3 small high still latched", 1'b1);
      tick = 1'b0;
      // R9 counter writes ignored
      wr(5'h00, 32'hDEADBEEF);
      wr(5'h04, 32'h00FFFFFF);
      rd(5'h00, m_cnt[31:0], "R9 cnt lo unchanged");
      rd(5'h04, m_cnt[63:32], "R9 cnt hi unchanged");
      // R4 compare halves
      wr(5'h0C, 32'hFFFFFFFF);
      rd(5'h0C, 32'h00FFFFFF, "R4 cmp hi masked");
      wr(5'h08, 32'h12345678);
      rd(5'h08, 32'h12345678, "R4 cmp lo");
      // R5 enable with future compare, status write ignored
      wr(5'h10, 32'hFFFFFFFF);
      rd(5'h10, 32'h1, "R5 ctrl only enable");
      check({31'h0, irq}, 32'h0, "R6 no fire in future");
      wr(5'h10, 32'h0);
      // R6 past compare fires one edge after enable
      wr(5'h0C, 32'h0);
      wr(5'h08, 32'h5);
      wr(5'h10, 32'h4);
      repeat (3) @(negedge clk);
      check({31'h0, irq}, 32'h0, "R7 no irq while disabled");
      rd(5'h10, 32'h0, "R5 status write ignored");
      wr(5'h10, 32'h1);
      check({31'h0, irq}, 32'h0, "R6 not yet on enable edge");
      @(negedge clk);
      check({31'h0, irq}, 32'h1, "R6 past compare fires");
      rd(5'h10, 32'h5, "R8 ctrl shows status");
      check({31'h0, irq}, 32'h1, "R8 irq equals status");
      // R7 acknowledge
      wr(5'h10, 32'h0);
      check({31'h0, irq}, 32'h0, "R7 clear drops irq");
      rd(5'h10, 32'h0, "R7 ctrl cleared");
      // R6 future compare, exact firing cycle
      cmpv = m_cnt[31:0] + 20;
      wr(5'h08, cmpv);
      wr(5'h10, 32'h1);
      tick = 1'b1;
      prev = 1'b0;
      for (int i = 0; i < 40; i++) begin
         check({31'h0, irq}, {31'h0, prev}, "R6 firing cycle");
         prev = prev | (m_cnt >= {32'h0, cmpv});
         @(negedge clk);
      end
      // R6 sticky after compare moves to future
      tick = 1'b0;
      wr(5'h08, 32'hFFFF0000);
      @(negedge clk);
      check({31'h0, irq}, 32'h1, "R6 sticky");
      wr(5'h10, 32'h0);
      check({31'h0, irq}, 32'h0, "R7 clear sticky");
      // R10 unmapped and idle bus
      rd(5'h14, 32'h0, "R10 unmapped 0x14");
      rd(5'h1C, 32'h0, "R10 unmapped 0x1C");
      #2;
      check(rdata, 32'h0, "R10 idle rdata");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule